// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block is the four-entry holding queue placed between a serial receiver and the processor's read path. The receiver offers bytes through a valid/ready pair; the queue takes them while reception is enabled and there is room. The oldest held byte comes out when the processor strobes a read, and it appears on the read data output one cycle later. Two status outputs report that data is waiting and that the queue is full. A flush input, driven by a receiver-reset command, discards everything held.

A line break is handled differently from a data byte. It is never refused: it enters as a zero byte. When the queue is already full, it replaces the newest entry so the count stays at four. A break also sets a sticky break-change flag, and that flag stays set until a clear input is pulsed.

Top module: `rx_hold_fifo`

## Requirements
- R1: Accepted bytes, including break zero bytes, leave in the order they entered, and up to DEPTH (default 4) of them are held.
- R2: `rx_ready_o` is high exactly when at least one byte is held. `full_o` is high exactly when DEPTH bytes are held. Both come from registered state.
- R3: `push_ready_o` equals `rx_en_i` AND NOT `full_o` AND NOT `brk_i` AND NOT `flush_i`. A byte is stored only in a cycle where both `push_valid_i` and `push_ready_o` are high. Otherwise the held contents do not change.
- R4: A `brk_i` pulse without `flush_i` stores a zero byte whatever the value of `rx_en_i`. If the queue is full and no read is taken in that cycle, the zero replaces the newest entry and the count stays at DEPTH. A read in the same cycle is applied first.
- R5: `brk_flag_o` is set in the cycle after any `brk_i` pulse. It is cleared in the cycle after `brk_clr_i` is high without `brk_i`. Set wins over clear.
- R6: A read strobe while the queue is empty drives `rd_data_o` to 0 in the next cycle and changes neither the contents nor the flags.
- R7: A read strobe on a non-empty queue removes the oldest byte. That byte is on `rd_data_o` from the next cycle until the next read strobe. Unless a break arrives in the same cycle, `full_o` is low afterwards.
- R8: A read and an accepted byte in the same cycle leave the count unchanged, and both take effect.
- R9: `flush_i` empties the queue in one cycle and clears `rx_ready_o` and `full_o`. A read strobe in that cycle yields 0 and a byte offered in that cycle is refused.
- R10: After `rst_ni` is low, the queue is empty, all flags are low and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enabled |
| push_valid_i | input | 1 | Received byte offered |
| push_data_i | input | DATA_W | Received byte |
| push_ready_o | output | 1 | Queue can accept a normal byte this cycle |
| brk_i | input | 1 | Break event pulse |
| brk_clr_i | input | 1 | Clear pulse for the break-change flag |
| flush_i | input | 1 | Receiver reset: discard all entries |
| rd_i | input | 1 | Read strobe for the receive buffer |
| rd_data_o | output | DATA_W | Byte taken by the last read strobe |
| rx_ready_o | output | 1 | At least one byte held |
| full_o | output | 1 | DEPTH bytes held |
| brk_flag_o | output | 1 | Sticky break-change flag |

## Verification
Directed phases first fill the queue to its limit and then drain it. This checks ordering and where the full flag sits, and shows the difference between a refused byte and an accepted one. Further cases send a break into a full queue, a break together with a read, and a read together with a push. These tell overwrite apart from append, and a balanced count apart from off-by-one updates. Reads on an empty queue and flushes with a read pending isolate the zero-return paths. A long random mix with biased read and push rates then exercises the occupancy levels against the queue model. Its rare breaks, clears, flushes and enable toggles cover priority collisions.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DATA_W = 8;
  localparam int unsigned RXQ_DEPTH  = 4;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int unsigned DEPTH = rxq_pkg::RXQ_DEPTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             push_valid_i,
  input  logic             brk_i,
  input  logic             flush_i,
  input  logic             rd_i,
  output logic             push_ready_o,
  output logic             wr_en_o,
  output logic             wr_brk_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic             rd_take_o,
  output logic             rd_zero_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic             rx_ready_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_after;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic             empty, over, do_push, do_brk;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign empty        = (cnt_q == '0);
  assign full_o       = (cnt_q == CNT_W'(DEPTH));
  assign rx_ready_o   = !empty;
  assign push_ready_o = rx_en_i && !full_o && !brk_i && !flush_i;
  assign do_push      = push_valid_i && push_ready_o;
  assign do_brk       = brk_i && !flush_i;
  assign rd_take_o    = rd_i && !empty && !flush_i;
  assign rd_zero_o    = rd_i && (empty || flush_i);
  assign rd_idx_o     = rd_ptr_q;

  // read is applied before the write decides between append and overwrite
  assign cnt_after = cnt_q - CNT_W'(rd_take_o);
  assign wr_en_o   = do_push || do_brk;
  assign wr_brk_o  = do_brk;
  assign over      = wr_en_o && (cnt_after == CNT_W'(DEPTH));
  assign wr_idx_o  = over ? ptr_dec(wr_ptr_q) : wr_ptr_q;

  always_comb begin
    if (flush_i) cnt_d = '0;
    else         cnt_d = cnt_after + CNT_W'(wr_en_o && !over);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (wr_en_o && !over) wr_ptr_q <= ptr_inc(wr_ptr_q);
        if (rd_take_o)        rd_ptr_q <= ptr_inc(rd_ptr_q);
      end
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DATA_W = rxq_pkg::RXQ_DATA_W,
  parameter int unsigned DEPTH  = rxq_pkg::RXQ_DEPTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_brk_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_take_i,
  input  logic              rd_zero_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] wr_val;

  assign wr_val = wr_brk_i ? '0 : wr_data_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(g))   mem_q[g] <= wr_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd_data_o <= '0;
    else if (rd_zero_i) rd_data_o <= '0;
    else if (rd_take_i) rd_data_o <= mem_q[rd_idx_i];
  end
endmodule

// File: rtl/rxq_brk_flag.sv
module rxq_brk_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_i,
  input  logic brk_clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_o <= 1'b0;
    else if (brk_i)     flag_o <= 1'b1;
    else if (brk_clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int unsigned DATA_W = rxq_pkg::RXQ_DATA_W,
  parameter int unsigned DEPTH  = rxq_pkg::RXQ_DEPTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              push_valid_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              push_ready_o,
  input  logic              brk_i,
  input  logic              brk_clr_i,
  input  logic              flush_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_ready_o,
  output logic              full_o,
  output logic              brk_flag_o
);
  logic             wr_en, wr_brk, rd_take, rd_zero;
  logic [PTR_W-1:0] wr_idx, rd_idx;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .rx_en_i, .push_valid_i, .brk_i, .flush_i, .rd_i,
    .push_ready_o,
    .wr_en_o(wr_en), .wr_brk_o(wr_brk), .wr_idx_o(wr_idx),
    .rd_take_o(rd_take), .rd_zero_o(rd_zero), .rd_idx_o(rd_idx),
    .rx_ready_o, .full_o
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_brk_i(wr_brk), .wr_idx_i(wr_idx), .wr_data_i(push_data_i),
    .rd_take_i(rd_take), .rd_zero_i(rd_zero), .rd_idx_i(rd_idx),
    .rd_data_o
  );

  rxq_brk_flag u_brk (
    .clk_i, .rst_ni, .brk_i, .brk_clr_i, .flag_o(brk_flag_o)
  );
endmodule

// File: rtl/rx_hold_fifo_chk.sv
module rx_hold_fifo_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              push_valid_i,
  input logic              push_ready_o,
  input logic              brk_i,
  input logic              brk_clr_i,
  input logic              flush_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rx_ready_o,
  input logic              full_o,
  input logic              brk_flag_o
);
  AST_FULL_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_ready_o); // R3
  AST_FULL_IMPLIES_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> rx_ready_o); // R2
  AST_BRK_KEEPS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && brk_i && !rd_i && !flush_i |=> full_o); // R4
  AST_BRK_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> brk_flag_o); // R5
  AST_CLR_DROPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_clr_i && !brk_i |=> !brk_flag_o); // R5
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !rx_ready_o |=> rd_data_o == '0); // R6
  AST_EMPTY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_o && !brk_i && !(push_valid_i && push_ready_o) |=> !rx_ready_o); // R6
  AST_READ_CLEARS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !brk_i |=> !full_o); // R7
  AST_DATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !rx_ready_o && !full_o); // R9
endmodule

bind rx_hold_fifo rx_hold_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .rx_en_i, .push_valid_i, .push_ready_o, .brk_i, .brk_clr_i,
  .flush_i, .rd_i, .rd_data_o, .rx_ready_o, .full_o, .brk_flag_o
);

// File: tb/rx_hold_fifo_tb.sv
`timescale 1ns/1ps
module rx_hold_fifo_tb;
  localparam int DW = 8;
  localparam int DP = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rx_en_i = 1'b0, push_valid_i = 1'b0, brk_i = 1'b0;
  logic          brk_clr_i = 1'b0, flush_i = 1'b0, rd_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic          push_ready_o, rx_ready_o, full_o, brk_flag_o;
  logic [DW-1:0] rd_data_o;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [DW-1:0] mq [$];
  logic [DW-1:0] m_rd = '0;
  bit            m_flag = 0;

  always #2.5 clk_i = ~clk_i;

  rx_hold_fifo u_dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: inputs already driven after a negedge
  task automatic step(input string tag);
    bit rdy;
    #1;
    rdy = rx_en_i && (mq.size() < DP) && !brk_i && !flush_i;
    chk(tag, "push_ready", push_ready_o, rdy);
    if (flush_i) begin
      mq.delete();
      if (rd_i) m_rd = '0;
    end else begin
      if (rd_i) m_rd = (mq.size() == 0) ? '0 : mq.pop_front();
      if (brk_i) begin
        if (mq.size() == DP) mq[DP-1] = '0;
        else mq.push_back('0);
      end else if (push_valid_i && rdy) mq.push_back(push_data_i);
    end
    if (brk_i) m_flag = 1;
    else if (brk_clr_i) m_flag = 0;
    @(negedge clk_i);
    chk(tag, "rd_data", rd_data_o, m_rd);
    chk(tag, "rx_ready", rx_ready_o, mq.size() != 0);
    chk(tag, "full", full_o, mq.size() == DP);
    chk(tag, "brk_flag", brk_flag_o, m_flag);
    {push_valid_i, brk_i, brk_clr_i, flush_i, rd_i} = '0;
  endtask

  task automatic push(input string tag, input logic [DW-1:0] d);
    push_valid_i = 1; push_data_i = d; step(tag);
  endtask
  task automatic rd(input string tag);
    rd_i = 1; step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10", "rx_ready", rx_ready_o, 0);
    chk("R10", "full", full_o, 0);
    chk("R10", "brk_flag", brk_flag_o, 0);
    chk("R10", "rd_data", rd_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: disabled receiver refuses data
    push("R3", 8'h11);
    rx_en_i = 1;
    // R1: fill and drain in order
    for (int i = 0; i < DP; i++) push("R1", 8'hA0 + 8'(i));
    push("R3", 8'h55);            // refused while full
    for (int i = 0; i < DP; i++) rd("R1");
    rd("R6");                     // empty read
    rd("R6");
    // R4: break into a full queue overwrites newest
    for (int i = 0; i < DP; i++) push("R4", 8'hB0 + 8'(i));
    brk_i = 1; step("R4");
    brk_i = 1; rd_i = 1; step("R4");  // read first, then append
    for (int i = 0; i < DP; i++) rd("R4");
    // R5: flag clear and set-wins
    brk_clr_i = 1; step("R5");
    brk_i = 1; brk_clr_i = 1; step("R5");
    brk_clr_i = 1; step("R5");
    rx_en_i = 0; brk_i = 1; step("R4");  // break enters with receiver off
    rx_en_i = 1;
    rd("R4");
    // R8: read and push together
    push("R8", 8'hC1);
    push("R8", 8'hC2);
    rd_i = 1; push("R8", 8'hC3);
    rd_i = 1; push("R8", 8'hC4);
    rd("R8"); rd("R8");
    // R9: flush with read and offered byte
    push("R9", 8'hD1); push("R9", 8'hD2);
    rd("R9");
    flush_i = 1; rd_i = 1; push("R9", 8'hD3);
    rd("R9");
    push("R9", 8'hD4); rd("R9");
    // R2/R7: random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      push_valid_i = ($urandom_range(0, 99) < 55);
      push_data_i  = DW'($urandom);
      rd_i         = ($urandom_range(0, 99) < 45);
      brk_i        = (r < 4);
      brk_clr_i    = (r >= 4 && r < 8);
      flush_i      = (r >= 8 && r < 10);
      if (r >= 97) rx_en_i = ~rx_en_i;
      step("R2_R7");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule